// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM

This block models a synchronous static RAM that can switch between reads and writes on consecutive clock edges without idle bus cycles. Every command is captured on a rising clock edge. Write data is taken from the data input a fixed number of edges after its command, chosen so that write data and read data occupy the same cycle slot relative to their commands. The bus can therefore carry read, write, read with no gaps. A mode input picks one of two timings. The registered-output timing returns data one edge later than the flow-through timing, and its write data also lags one edge more.

The array holds 256 words of four 9-bit bytes, and each byte has its own active-low write enable. A two-bit burst counter lets a command continue at the next address without a new address being presented. A clock-enable input freezes the whole block, and a sleep input stops all operations and turns off the output. Separate data-in and data-out ports replace the bidirectional bus. A drive-enable output tells the surrounding logic when the read data is valid and should be driven. An asynchronous active-low output enable can take the bus off at any moment.

If a read in registered mode falls on the same edge as the completion of a pending write to the same word, the block merges the write data into the returned word. The read therefore sees the newest content.

Top module: `nbt_sram`

## Requirements
- R1: An edge starts a new command only when `clk_en_n`=0, `sleep`=0 and `cont`=0, with `sel1_n`=0, `sel2`=1 and `sel3_n`=0. `wr_n`=1 selects a read and `wr_n`=0 selects a write. A load edge with any select inactive deselects the device: memory is unchanged and the bus is not driven for that command.
- R2: With `flow_thru`=0, read data is on `dout` with `dout_en`=1 in the cycle that follows the second active edge, counting the command edge as the first.
- R3: With `flow_thru`=1, read data is on `dout` in the cycle that directly follows the command edge.
- R4: With `flow_thru`=0, the data for a write is taken from `din` at the third active edge, counting the command edge as the first.
- R5: With `flow_thru`=1, the data for a write is taken from `din` at the second active edge. In either mode the bus is not driven for a write command.
- R6: Byte i of the word is `din[9i+8:9i]` and is written only when `bw_n[i]`=0. A write with `bw_n`=4'b1111 leaves memory unchanged.
- R7: An edge with `cont`=1 repeats the type of the previous command. It uses the address whose low two bits are incremented modulo 4, keeps the upper bits, and takes the byte enables sampled at that edge. A continue that follows a deselect stays deselected.
- R8: An edge with `clk_en_n`=1 changes no state. A read being shown stays driven with the same data, and a write in progress keeps the bus off.
- R9: `oe_n`=1 forces `dout_en` low at once without changing any state. A read issued with `oe_n`=1 is a dummy read.
- R10: While `sleep`=1, `dout_en` is low and edges perform no operation.
- R11: With `flow_thru`=0, a read issued on the edge directly after a write to the same word returns the written bytes merged over the stored ones.
- R12: After reset, and whenever `dout_en`=0, `dout` is all zeros and nothing is driven.
- R13: `flow_thru` may change only while no command is in flight. The latency difference of R2 and R3 then applies from the next command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en_n | input | 1 | Active-low clock enable; high freezes the block |
| sel1_n | input | 1 | Chip select, active low |
| sel2 | input | 1 | Chip select, active high |
| sel3_n | input | 1 | Chip select, active low |
| cont | input | 1 | 0 loads a new command, 1 continues the burst |
| wr_n | input | 1 | 1 read, 0 write |
| bw_n | input | 4 | Active-low byte write enables |
| addr | input | 8 | Word address |
| din | input | 36 | Write data, taken at the late-write edge |
| flow_thru | input | 1 | 1 flow-through timing, 0 registered-output timing |
| oe_n | input | 1 | Asynchronous active-low output enable |
| sleep | input | 1 | Asynchronous sleep; high idles the block |
| dout | output | 36 | Read data, zero when not driven |
| dout_en | output | 1 | Drive enable for the data bus |

## Verification
A command stage that holds the wrong state first shows up on the bus. It appears as data in the wrong cycle, a drive enable during a write, or a continue that reads the wrong burst address, and it is seen within one or two edges of the faulty command. A late-write stage that uses the wrong edge or the wrong byte mask leaves no trace until the affected word is read back. For that reason the stimulus reads back every written word, including the words touched by aborted and deselected writes. A bypass fault shows only in a back-to-back write and read to the same word, so that pattern is driven in both modes.

// File: rtl/nbt_pkg.sv
package nbt_pkg;
    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_RD   = 2'd1,
        OP_WR   = 2'd2
    } op_e;

    localparam int BURST_W = 2;
endpackage

// File: rtl/nbt_ctrl.sv
module nbt_ctrl #(
    parameter int ADDR_W = 8,
    parameter int NBYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold,
    input  logic              flow,
    input  logic              cont,
    input  logic              sel_ok,
    input  logic              wr_n,
    input  logic [NBYTES-1:0] bw_n,
    input  logic [ADDR_W-1:0] addr,
    output logic              rd_vld,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_go,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [NBYTES-1:0] wr_be
);
    import nbt_pkg::*;

    localparam int BW = BURST_W;

    typedef struct packed {
        op_e               op;
        logic [ADDR_W-1:0] addr;
        logic [NBYTES-1:0] be;
    } stage_t;

    typedef struct packed {
        stage_t s1;
        stage_t s2;
    } ctrl_t;

    ctrl_t  st_q, st_d;
    stage_t cmd_d;
    stage_t wstg;

    function automatic logic [ADDR_W-1:0] burst_next(input logic [ADDR_W-1:0] a);
        return {a[ADDR_W-1:BW], a[BW-1:0] + BW'(1)};
    endfunction

    always_comb begin
        st_d  = st_q;
        cmd_d = st_q.s1;
        if (!cont) begin
            cmd_d.addr = addr;
            if (sel_ok) begin
                cmd_d.op = wr_n ? OP_RD : OP_WR;
            end else begin
                cmd_d.op = OP_IDLE;
            end
        end else begin
            cmd_d.addr = burst_next(st_q.s1.addr);
            cmd_d.op   = st_q.s1.op;
        end
        cmd_d.be = (cmd_d.op == OP_WR) ? ~bw_n : '0;
        if (!hold) begin
            st_d.s2 = st_q.s1;
            st_d.s1 = cmd_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wstg    = flow ? st_q.s1 : st_q.s2;
    assign rd_vld  = (st_q.s1.op == OP_RD);
    assign rd_addr = st_q.s1.addr;
    assign wr_go   = !hold && (wstg.op == OP_WR) && (|wstg.be);
    assign wr_addr = wstg.addr;
    assign wr_be   = wstg.be;
endmodule

// File: rtl/nbt_array.sv
module nbt_array #(
    parameter  int ADDR_W = 8,
    parameter  int NBYTES = 4,
    parameter  int BYTE_W = 9,
    localparam int DATA_W = NBYTES * BYTE_W,
    localparam int DEPTH  = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [NBYTES-1:0] wbe,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    for (genvar b = 0; b < NBYTES; b++) begin : g_lane
        logic [BYTE_W-1:0] lane_q [DEPTH];

        always_ff @(posedge clk) begin
            if (we && wbe[b]) begin
                lane_q[waddr] <= wdata[b*BYTE_W +: BYTE_W];
            end
        end

        assign rdata[b*BYTE_W +: BYTE_W] = lane_q[raddr];
    end
endmodule

// File: rtl/nbt_outpath.sv
module nbt_outpath #(
    parameter  int ADDR_W = 8,
    parameter  int NBYTES = 4,
    parameter  int BYTE_W = 9,
    localparam int DATA_W = NBYTES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold,
    input  logic              flow,
    input  logic              rd_vld,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] rdata,
    input  logic              wr_go,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [NBYTES-1:0] wr_be,
    input  logic [DATA_W-1:0] din,
    input  logic              oe_n,
    input  logic              sleep,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en
);
    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] data;
    } out_t;

    out_t              oq_q, oq_d;
    logic [DATA_W-1:0] merged;
    logic              byp_hit;
    logic              src_vld;
    logic [DATA_W-1:0] src_data;

    assign byp_hit = wr_go && (wr_addr == rd_addr);

    always_comb begin
        merged = rdata;
        for (int b = 0; b < NBYTES; b++) begin
            if (byp_hit && wr_be[b]) begin
                merged[b*BYTE_W +: BYTE_W] = din[b*BYTE_W +: BYTE_W];
            end
        end
    end

    always_comb begin
        oq_d = oq_q;
        if (!hold) begin
            oq_d.vld = rd_vld;
            if (rd_vld) begin
                oq_d.data = merged;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            oq_q <= '0;
        end else begin
            oq_q <= oq_d;
        end
    end

    assign src_vld  = flow ? rd_vld : oq_q.vld;
    assign src_data = flow ? rdata  : oq_q.data;
    assign dout_en  = src_vld && !oe_n && !sleep;
    assign dout     = dout_en ? src_data : '0;
endmodule

// File: rtl/nbt_sram.sv
module nbt_sram #(
    parameter  int ADDR_W = 8,
    parameter  int NBYTES = 4,
    parameter  int BYTE_W = 9,
    localparam int DATA_W = NBYTES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en_n,
    input  logic              sel1_n,
    input  logic              sel2,
    input  logic              sel3_n,
    input  logic              cont,
    input  logic              wr_n,
    input  logic [NBYTES-1:0] bw_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    input  logic              flow_thru,
    input  logic              oe_n,
    input  logic              sleep,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en
);
    logic              hold;
    logic              sel_ok;
    logic              rd_vld;
    logic [ADDR_W-1:0] rd_addr;
    logic              wr_go;
    logic [ADDR_W-1:0] wr_addr;
    logic [NBYTES-1:0] wr_be;
    logic [DATA_W-1:0] rdata;

    assign hold   = clk_en_n || sleep;
    assign sel_ok = !sel1_n && sel2 && !sel3_n;

    nbt_ctrl #(.ADDR_W(ADDR_W), .NBYTES(NBYTES)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .hold    (hold),
        .flow    (flow_thru),
        .cont    (cont),
        .sel_ok  (sel_ok),
        .wr_n    (wr_n),
        .bw_n    (bw_n),
        .addr    (addr),
        .rd_vld  (rd_vld),
        .rd_addr (rd_addr),
        .wr_go   (wr_go),
        .wr_addr (wr_addr),
        .wr_be   (wr_be)
    );

    nbt_array #(.ADDR_W(ADDR_W), .NBYTES(NBYTES), .BYTE_W(BYTE_W)) u_array (
        .clk   (clk),
        .we    (wr_go),
        .waddr (wr_addr),
        .wbe   (wr_be),
        .wdata (din),
        .raddr (rd_addr),
        .rdata (rdata)
    );

    nbt_outpath #(.ADDR_W(ADDR_W), .NBYTES(NBYTES), .BYTE_W(BYTE_W)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .hold    (hold),
        .flow    (flow_thru),
        .rd_vld  (rd_vld),
        .rd_addr (rd_addr),
        .rdata   (rdata),
        .wr_go   (wr_go),
        .wr_addr (wr_addr),
        .wr_be   (wr_be),
        .din     (din),
        .oe_n    (oe_n),
        .sleep   (sleep),
        .dout    (dout),
        .dout_en (dout_en)
    );
endmodule

// File: rtl/nbt_sram_chk.sv
module nbt_sram_chk #(
    parameter int DATA_W = 36
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clk_en_n,
    input logic              sel1_n,
    input logic              sel2,
    input logic              sel3_n,
    input logic              cont,
    input logic              wr_n,
    input logic              flow_thru,
    input logic              oe_n,
    input logic              sleep,
    input logic [DATA_W-1:0] dout,
    input logic              dout_en
);
    logic live_q;
    logic sel_ok;
    logic go;

    assign sel_ok = !sel1_n && sel2 && !sel3_n;
    assign go     = !clk_en_n && !sleep && !cont;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            live_q <= 1'b0;
        end else begin
            live_q <= 1'b1;
        end
    end

    // R12
    undriven_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_en |-> (dout == '0));

    // R10
    sleep_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> !dout_en);

    // R9
    oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !dout_en);

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(clk_en_n) && $stable(oe_n) && $stable(sleep) && $stable(flow_thru))
        |-> ($stable(dout) && $stable(dout_en)));

    // R1
    flow_noread_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flow_thru && go && !(sel_ok && wr_n)) |=> (!flow_thru || !dout_en));

    // R5
    pipe_write_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!flow_thru && go && sel_ok && !wr_n) ##1 (!clk_en_n && !sleep)
        |=> (flow_thru || !dout_en));
endmodule

bind nbt_sram nbt_sram_chk #(.DATA_W(NBYTES * BYTE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clk_en_n  (clk_en_n),
    .sel1_n    (sel1_n),
    .sel2      (sel2),
    .sel3_n    (sel3_n),
    .cont      (cont),
    .wr_n      (wr_n),
    .flow_thru (flow_thru),
    .oe_n      (oe_n),
    .sleep     (sleep),
    .dout      (dout),
    .dout_en   (dout_en)
);

// File: tb/sim_nbt_sram.sv
`timescale 1ns/1ps
module sim_nbt_sram;
    localparam int AW = 8;
    localparam int NB = 4;
    localparam int BYW = 9;
    localparam int DW = NB * BYW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clk_en_n = 1'b1;
    logic          sel1_n = 1'b1;
    logic          sel2 = 1'b0;
    logic          sel3_n = 1'b1;
    logic          cont = 1'b0;
    logic          wr_n = 1'b1;
    logic [NB-1:0] bw_n = '1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din = '0;
    logic          flow_thru = 1'b0;
    logic          oe_n = 1'b0;
    logic          sleep = 1'b0;
    logic [DW-1:0] dout;
    logic          dout_en;

    int          total = 0;
    int          bad = 0;
    logic [31:0] cnt = 32'd1;
    string       cur_req = "R12";

    nbt_sram u0 (
        .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .sel1_n(sel1_n), .sel2(sel2),
        .sel3_n(sel3_n), .cont(cont), .wr_n(wr_n), .bw_n(bw_n), .addr(addr), .din(din),
        .flow_thru(flow_thru), .oe_n(oe_n), .sleep(sleep), .dout(dout), .dout_en(dout_en)
    );

    always #5 clk = ~clk;

    // reference model
    logic [DW-1:0] m_mem [0:255];
    int            m_op = 0;
    int            m_addr = 0;
    int            wq_a[$];
    int            wq_be[$];
    int            wq_c[$];
    bit            pend = 1'b0;
    int            pend_a = 0;
    bit            e_vld = 1'b0;
    logic [DW-1:0] e_data = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_op = 0; pend = 0; e_vld = 0; e_data = '0;
            wq_a.delete(); wq_be.delete(); wq_c.delete();
        end else if (!clk_en_n && !sleep) begin
            foreach (wq_c[i]) wq_c[i] = wq_c[i] - 1;
            while (wq_c.size() > 0 && wq_c[0] == 0) begin
                for (int b = 0; b < NB; b++)
                    if (wq_be[0][b]) m_mem[wq_a[0]][b*BYW +: BYW] = din[b*BYW +: BYW];
                void'(wq_a.pop_front()); void'(wq_be.pop_front()); void'(wq_c.pop_front());
            end
            e_vld = 0;
            if (pend) begin
                e_vld = 1; e_data = m_mem[pend_a]; pend = 0;
            end
            if (!cont) begin
                if (!sel1_n && sel2 && !sel3_n) begin
                    m_op = wr_n ? 1 : 2;
                    m_addr = int'(addr);
                end else begin
                    m_op = 0;
                end
            end else if (m_op != 0) begin
                m_addr = (m_addr & ~3) | ((m_addr + 1) & 3);
            end
            if (m_op == 1) begin
                if (flow_thru) begin
                    e_vld = 1; e_data = m_mem[m_addr];
                end else begin
                    pend = 1; pend_a = m_addr;
                end
            end
            if (m_op == 2 && bw_n != '1) begin
                wq_a.push_back(m_addr);
                wq_be.push_back(int'(~bw_n));
                wq_c.push_back(flow_thru ? 1 : 2);
            end
        end
    end

    task automatic check(input string req, input bit ok, input logic [DW-1:0] act,
                         input logic [DW-1:0] exp, input bit act_en, input bit exp_en);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: dout_en=%0b dout=%h expected dout_en=%0b dout=%h",
                     req, act_en, act, exp_en, exp);
        end
    endtask

    task automatic compare();
        bit            x_en;
        logic [DW-1:0] x_d;
        x_en = e_vld && !oe_n && !sleep;
        x_d  = x_en ? e_data : '0;
        check(cur_req, (dout_en === x_en) && (dout === x_d), dout, x_d, dout_en, x_en);
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
        compare();
        cnt = cnt + 1;
        din = {cnt[3:0], cnt * 32'h9E3779B1};
    endtask

    task automatic drive(input bit ce, input bit s1n, input bit s2, input bit s3n,
                         input bit c, input bit wn, input logic [AW-1:0] a,
                         input logic [NB-1:0] b);
        clk_en_n = ce; sel1_n = s1n; sel2 = s2; sel3_n = s3n;
        cont = c; wr_n = wn; addr = a; bw_n = b;
    endtask

    task automatic nw(input logic [AW-1:0] a, input logic [NB-1:0] b);
        drive(0, 0, 1, 0, 0, 0, a, b); cyc();
    endtask
    task automatic nr(input logic [AW-1:0] a);
        drive(0, 0, 1, 0, 0, 1, a, '1); cyc();
    endtask
    task automatic ct(input logic [NB-1:0] b);
        drive(0, 1, 0, 1, 1, 1, addr, b); cyc();
    endtask
    task automatic ds(input int n);
        for (int i = 0; i < n; i++) begin
            drive(0, 1, 1, 0, 0, 1, addr, '1); cyc();
        end
    endtask
    task automatic st(input int n);
        for (int i = 0; i < n; i++) begin
            clk_en_n = 1'b1; cyc();
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12: reset state
        check("R12", (dout_en === 1'b0) && (dout === '0), dout, '0, dout_en, 1'b0);
        compare();
        rst_n = 1'b1;
        ds(2);

        // registered-output timing
        cur_req = "R4";
        nw(8'h10, 4'h0); nw(8'h11, 4'h0); nw(8'h12, 4'h0); nw(8'h13, 4'h0);
        cur_req = "R2";
        nr(8'h10); nr(8'h11); nr(8'h12); nr(8'h13); ds(3);
        // back-to-back write then read, same word (bypass)
        cur_req = "R11";
        nw(8'h10, 4'b0101); nr(8'h10); nw(8'h11, 4'b1110); nr(8'h11);
        nw(8'h12, 4'b0000); nr(8'h13); nr(8'h12); ds(3);
        // byte mask and write abort
        cur_req = "R6";
        nw(8'h12, 4'b1010); nw(8'h13, 4'b1111); ds(2);
        nr(8'h12); nr(8'h13); ds(3);
        // burst with wrap, continue after deselect
        cur_req = "R7";
        nw(8'h23, 4'h0); ct(4'h0); ct(4'b0011); ct(4'h0); ds(2);
        nr(8'h22); ct(4'hF); ct(4'hF); ct(4'hF); ds(1); ct(4'hF); ct(4'hF); ds(2);
        // deselected commands do nothing
        cur_req = "R1";
        drive(0, 0, 1, 1, 0, 0, 8'h10, 4'h0); cyc();
        drive(0, 0, 0, 0, 0, 1, 8'h10, 4'hF); cyc();
        drive(0, 1, 1, 0, 0, 0, 8'h11, 4'h0); cyc();
        ds(3); nr(8'h10); nr(8'h11); ds(3);
        // stall during read and during write
        cur_req = "R8";
        nr(8'h20); st(3); nr(8'h21); st(2); ds(3);
        nw(8'h24, 4'h0); st(2); ds(1); st(1); ds(3); nr(8'h24); ds(3);
        // output enable gating, dummy read
        cur_req = "R9";
        oe_n = 1'b1; nr(8'h20); ds(1);
        oe_n = 1'b0; st(1); oe_n = 1'b1; st(1); oe_n = 1'b0; ds(3);
        // sleep
        cur_req = "R10";
        sleep = 1'b1; nw(8'h20, 4'h0); nw(8'h21, 4'h0); nr(8'h20);
        sleep = 1'b0; ds(3); nr(8'h20); ds(1);
        sleep = 1'b1; st(0); cyc(); sleep = 1'b0; ds(3);

        // flow-through timing
        cur_req = "R13";
        flow_thru = 1'b1; ds(2);
        cur_req = "R5";
        nw(8'h40, 4'h0); nw(8'h41, 4'h0); nw(8'h42, 4'b0110); nw(8'h43, 4'h0);
        cur_req = "R3";
        nr(8'h40); nr(8'h41); nr(8'h42); nr(8'h43); ds(2);
        nw(8'h40, 4'b1100); nr(8'h40); nw(8'h41, 4'h0); nr(8'h41); nr(8'h41); ds(2);
        cur_req = "R7";
        nw(8'h42, 4'h0); ct(4'h0); ct(4'h0); ct(4'b1000); nr(8'h43); ct(4'hF); ct(4'hF); ct(4'hF); ds(2);
        cur_req = "R8";
        nr(8'h41); st(2); nw(8'h41, 4'h0); st(1); ds(1); nr(8'h41); ds(2);
        cur_req = "R13";
        flow_thru = 1'b0; ds(1); nr(8'h40); ds(3);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule